// File: doc/BRIEF.md
# Invert-B Four-Function ALU

This block is a purely combinational arithmetic-logic unit of parameterised width. It takes two operands and a 3-bit function code and returns one result word together with a flag that is high when that word is all zeros. It sits in a processor datapath. There, the flag feeds an equality branch decision after a subtraction, and the result feeds address generation, register write-back, and signed comparison.

The two low bits of the function code pick one of four result sources:

- bitwise AND,
- bitwise OR,
- the sum from a single shared adder,
- a one-bit less-than value.

The high bit complements the second operand before it reaches either the logic gates or the adder. The same high bit is also the adder's carry input. One adder therefore serves for addition, for subtraction, and for the comparison. The comparison result is the sign bit of the difference, extended with zeros to full width. Signed overflow is not corrected: an overflowing difference gives the sign bit of the wrapped value.

The adder structure is selected by a parameter. The choices are a parallel-prefix carry network or a plain behavioural adder. Both choices give identical results.

Top module: `alu_inv_b`

## Requirements
- R1: Function code 3'b000 gives the bitwise AND of A and B.
- R2: Function code 3'b001 gives the bitwise OR of A and B.
- R3: Function code 3'b010 gives A plus B, wrapping modulo 2^WIDTH.
- R4: Function code 3'b110 gives A minus B in two's complement, wrapping modulo 2^WIDTH.
- R5: Function code 3'b111 gives a result whose bit 0 is bit WIDTH-1 of the wrapped difference A minus B, and whose upper bits are all zero. When the subtraction does not overflow, this equals 1 for signed A less than B and 0 otherwise.
- R6: Function code 3'b100 gives A AND (NOT B). Function code 3'b101 gives A OR (NOT B).
- R7: Function code 3'b011 gives an all-zero result, whatever the operands are.
- R8: The zero flag is 1 exactly when the result is all zeros, for every function code.
- R9: The result and the zero flag depend only on the present inputs, with no storage. A new input value is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| func_i | input | 3 | Function code: bit 2 inverts B and drives the carry-in; bits 1:0 select the source |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench targets the carry path at its extremes:

- All-ones plus one must wrap to zero with the flag set. An adder that drops the top carry stage or mishandles carry-in would leave stray bits.
- Zero minus one must give all ones. A design that inverts B but forgets the carry-in would return all ones minus one.

For the comparison, the bench uses equal operands, operands that differ only in sign, and the overflowing pair (most-negative, 1). That pair must return 0 under the sign-bit rule. A design that took the carry-out or a true signed compare instead would return 1 there.

Code 011 is driven with operands whose sum is nonzero, so a design that let the sum through would show it. The inverted-B logic codes are driven with operand patterns where the plain and inverted results differ, so a design that ignored bit 2 for the logic sources would show it.

// File: rtl/alu_inv_b_pkg.sv
package alu_inv_b_pkg;
  localparam int unsigned FUNC_W = 3;
  localparam int unsigned INV_BIT = 2;

  typedef enum logic [1:0] {
    SRC_AND = 2'b00,
    SRC_OR  = 2'b01,
    SRC_SUM = 2'b10,
    SRC_LT  = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic     inv_b;
    src_sel_e src;
  } func_t;

  function automatic func_t decode_func(input logic [FUNC_W-1:0] code);
    func_t d;
    d.inv_b = code[INV_BIT];
    d.src   = src_sel_e'(code[1:0]);
    return d;
  endfunction
endpackage

// File: rtl/alu_inv_b_operand.sv
module alu_inv_b_operand #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_o,
  output logic             cin_o
);
  always_comb begin
    b_o   = inv_i ? ~b_i : b_i;
    cin_o = inv_i;
  end
endmodule

// File: rtl/alu_inv_b_adder.sv
module alu_inv_b_adder #(
  parameter int unsigned WIDTH       = 32,
  parameter bit          USE_PREFIX  = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  if (USE_PREFIX) begin : g_prefix
    logic [LEVELS:0][WIDTH-1:0] gen;
    logic [LEVELS:0][WIDTH-1:0] prop;
    logic [WIDTH-1:0]           half;
    logic [WIDTH-1:0]           carry;

    assign half = a_i ^ b_i;

    // carry-in folded into bit 0 generate
    assign gen[0]  = (a_i & b_i) | {{(WIDTH-1){1'b0}}, half[0] & cin_i};
    assign prop[0] = half;

    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_level
      localparam int unsigned DIST = 1 << (lv - 1);
      for (genvar bt = 0; bt < WIDTH; bt++) begin : g_bit
        if (bt >= DIST) begin : g_merge
          assign gen[lv][bt]  = gen[lv-1][bt] | (prop[lv-1][bt] & gen[lv-1][bt-DIST]);
          assign prop[lv][bt] = prop[lv-1][bt] & prop[lv-1][bt-DIST];
        end else begin : g_pass
          assign gen[lv][bt]  = gen[lv-1][bt];
          assign prop[lv][bt] = prop[lv-1][bt];
        end
      end
    end

    assign carry[0] = cin_i;
    for (genvar bt = 1; bt < WIDTH; bt++) begin : g_carry
      assign carry[bt] = gen[LEVELS][bt-1];
    end

    assign sum_o = half ^ carry;
  end else begin : g_plain
    assign sum_o = a_i + b_i + {{(WIDTH-1){1'b0}}, cin_i};
  end
endmodule

// File: rtl/alu_inv_b_resmux.sv
module alu_inv_b_resmux
  import alu_inv_b_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_eff_i,
  input  logic [WIDTH-1:0] sum_i,
  input  func_t            func_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  always_comb begin
    unique case (func_i.src)
      SRC_AND: result_o = a_i & b_eff_i;
      SRC_OR:  result_o = a_i | b_eff_i;
      SRC_SUM: result_o = sum_i;
      SRC_LT:  begin
        // 011 has no defined use: force zero; 111 takes the sign of the difference
        result_o = '0;
        if (func_i.inv_b) result_o[0] = sum_i[WIDTH-1];
      end
      default: result_o = '0;
    endcase
    zero_o = ~|result_o;
  end
endmodule

// File: rtl/alu_inv_b.sv
module alu_inv_b
  import alu_inv_b_pkg::*;
#(
  parameter int unsigned WIDTH      = 32,
  parameter bit          USE_PREFIX = 1'b1
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o
);
  func_t            dec;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;

  assign dec = decode_func(func_i);

  alu_inv_b_operand #(.WIDTH(WIDTH)) i_operand (
    .b_i   (b_i),
    .inv_i (dec.inv_b),
    .b_o   (b_eff),
    .cin_o (cin)
  );

  alu_inv_b_adder #(.WIDTH(WIDTH), .USE_PREFIX(USE_PREFIX)) i_adder (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (cin),
    .sum_o (sum)
  );

  alu_inv_b_resmux #(.WIDTH(WIDTH)) i_resmux (
    .a_i      (a_i),
    .b_eff_i  (b_eff),
    .sum_i    (sum),
    .func_i   (dec),
    .result_o (result_o),
    .zero_o   (zero_o)
  );
endmodule

// File: rtl/alu_inv_b_checker.sv
module alu_inv_b_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       func_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);
  always_comb begin
    if (func_i == 3'b000) assert_and_R1: assert (result_o == (a_i & b_i));
    if (func_i == 3'b001) assert_or_R2: assert (result_o == (a_i | b_i));
    if (func_i == 3'b010) assert_add_R3: assert (result_o == a_i + b_i);
    if (func_i == 3'b110) assert_sub_R4: assert (result_o + b_i == a_i);
    if (func_i == 3'b111) assert_lt_width_R5: assert (result_o[WIDTH-1:1] == '0);
    if (func_i == 3'b100) assert_andn_R6: assert ((result_o & b_i) == '0);
    if (func_i == 3'b101) assert_orn_R6: assert ((result_o | b_i) == '1);
    if (func_i == 3'b011) assert_unused_R7: assert (result_o == '0);
    assert_zero_flag_R8: assert (zero_o == (result_o == '0));
  end
endmodule

bind alu_inv_b alu_inv_b_checker #(.WIDTH(WIDTH)) i_alu_inv_b_checker (
  .a_i      (a_i),
  .b_i      (b_i),
  .func_i   (func_i),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/test_alu_inv_b.sv
`timescale 1ns/1ps
module test_alu_inv_b;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, y;
  logic [2:0]   f;
  logic         z;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  alu_inv_b #(.WIDTH(W)) i_alu_inv_b (
    .a_i(a), .b_i(b), .func_i(f), .result_o(y), .zero_o(z)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] v,
                                         input logic [2:0] op);
    logic [W-1:0] d;
    d = x - v;
    case (op)
      3'd0: return x & v;
      3'd1: return x | v;
      3'd2: return x + v;
      3'd3: return '0;
      3'd4: return x & ~v;
      3'd5: return x | ~v;
      3'd6: return d;
      default: return {{(W-1){1'b0}}, d[W-1]};
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R7";
      3'd4, 3'd5: return "R6";
      3'd6: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic expect_eq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h f=%b)", req, act, exp, a, b, f);
    end
  endtask

  // drive after a rising edge, sample at the following falling edge (R9: same cycle)
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] v, input logic [2:0] op);
    logic [W-1:0] e;
    @(posedge clk);
    a = x; b = v; f = op;
    e = model(x, v, op);
    @(negedge clk);
    expect_eq(tag(op), y, e);
    expect_eq("R8", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, (e == '0)});
  endtask

  initial begin
    a = '0; b = '0; f = 3'd0;
    repeat (2) @(negedge clk);
    // reset window: zero inputs give zero result and a set flag
    expect_eq("R1", y, '0);
    expect_eq("R8", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, 1'b1});
    rst_ni = 1'b1;

    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'd0);         // R1
    apply(32'hF000_0000, 32'h0000_000F, 3'd1);         // R2
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd2);         // R3 wrap to zero
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'd2);         // R3 carry ripples full width
    apply(32'h0000_0000, 32'h0000_0001, 3'd6);         // R4 borrow to all ones
    apply(32'h1234_5678, 32'h1234_5678, 3'd6);         // R4 equal -> zero flag
    apply(32'h0000_0005, 32'h0000_0005, 3'd7);         // R5 equal -> 0
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd7);         // R5 -1 < 1 -> 1
    apply(32'h0000_0001, 32'hFFFF_FFFF, 3'd7);         // R5 1 < -1 false
    apply(32'h8000_0000, 32'h0000_0001, 3'd7);         // R5 overflowing pair -> sign bit 0
    apply(32'hFF00_FF00, 32'h0F0F_0F0F, 3'd4);         // R6 and-not
    apply(32'h0000_0000, 32'hFFFF_0000, 3'd5);         // R6 or-not
    apply(32'h1234_5678, 32'h1111_1111, 3'd3);         // R7 nonzero sum suppressed
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd3);         // R7

    // pseudo-random sweep over all codes (R1..R8)
    begin
      logic [W-1:0] s;
      s = 32'h1D87_2B41;
      for (int i = 0; i < 4000; i++) begin
        logic [W-1:0] x, v;
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        x = s;
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        v = (i % 7 == 0) ? x : s;
        apply(x, v, 3'(i));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule